// File: doc/BRIEF.md
# Serial Multichannel DAC Register Front End

This block is the digital register core for a bank of voltage-output converters, loaded over a three-wire serial link. The link has an active-low frame sync, a serial clock and a data line. All three are oversampled in the block's own clock domain. Each frame carries one 16-bit word, sent most significant bit first. A two-bit mode field in the word sends it to one of three places: the system control register, one channel's control register, or one channel's data registers.

Each channel has a 10-bit main code and an 8-bit trim (sub) code. Both are double buffered. A write fills only the holding (data) register. The active (DAC) register that drives the converter changes only when the load strobe is low. The load strobe can be pulsed on its own, or held low across a frame so that the write takes effect at once. A clear input puts every channel back to its bias-centred code. An input-coding bit chooses what that code is.

The serial receiver is a three-state machine:
- **RX_IDLE** waits with frame sync high.
- **IDLE→SHIFT** happens when frame sync goes low.
- **RX_SHIFT** counts accepted falling serial-clock edges.
- **SHIFT→IDLE** happens when frame sync rises before the count reaches 16. The partial word is dropped.
- **SHIFT→DRAIN** happens on the sixteenth edge. This transition also commits the word.
- **RX_DRAIN** ignores any further edges.
- **DRAIN→IDLE** happens when frame sync rises.

Top module: `dacfe_core`

## Requirements
- R1: A word is 16 bits, shifted in MSB first. A bit is taken on each falling edge of `sclk` while `fsync_n` is low. The word is committed on the sixteenth such edge.
- R2: Word bits [14:13] are the mode field: 00 writes the system control register, 01 writes a channel control register, and 1x writes a data register. For data writes, bit 12 selects main (0) or sub (1), and bits [11:10] give the channel. A main write takes bits [9:0]; a sub write takes bits [7:0] and ignores bits [9:8].
- R3: A frame that ends with fewer than 16 edges writes nothing. Edges after the sixteenth in the same frame are ignored.
- R4: While `ldac_n` and `clr_n` are high, `main_code` and `sub_code` stay unchanged, even when data writes arrive.
- R5: While `ldac_n` is low, every channel's DAC registers take the contents of its data registers.
- R6: If `ldac_n` is low when the sixteenth edge commits a data write, the new code appears on the outputs without any further strobe.
- R7: When `clr_n` is low, every main register (data and DAC) is set to 0x200 if `coding_twos` is 0, or to 0x000 if it is 1. Every sub register is set to 0x80. Clear has priority over writes. Control registers are not changed.
- R8: A system control write sets `coding_twos` from bit 0, `sys_standby` from bit 1 and `sys_powerdown` from bit 2. A channel control write to the channel in bits [11:10] sets its standby from bit 0 and its bias select from bits [2:1].
- R9: After `rst_n` goes low, all main codes are 0x200, all sub codes are 0x80, and all control bits are 0.
- R10: Bit 15 of the word has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; bits are taken on its falling edge |
| fsync_n | input | 1 | Active-low frame sync, level sensitive |
| sdin | input | 1 | Serial data |
| ldac_n | input | 1 | Active-low load strobe, data to DAC registers (clk-synchronous) |
| clr_n | input | 1 | Active-low clear to bias-centred codes (clk-synchronous) |
| main_code | output | CHANNELS*10 | Active main codes; channel c is at [c*10 +: 10] |
| sub_code | output | CHANNELS*8 | Active sub codes; channel c is at [c*8 +: 8] |
| coding_twos | output | 1 | 1 = twos-complement main coding |
| sys_standby | output | 1 | System standby |
| sys_powerdown | output | 1 | System power-down |
| ch_standby | output | CHANNELS | Per-channel standby |
| ch_bias_sel | output | CHANNELS*2 | Per-channel bias select; channel c is at [c*2 +: 2] |

## Verification
The bench drives directed frames of 10, 16 and 20 edges:
- The short frame shows that a partial word is discarded.
- The long frame shows that edges after the sixteenth are ignored.

Each write is followed by a check with `ldac_n` high and then a check after a strobe. This separates holding-register updates from DAC-register updates. Running the same write with `ldac_n` held low across the frame confirms the automatic update.

Clear is applied under both coding settings, which shows the main clear code depends on `coding_twos`. A sub write with junk in bits [9:8], and a data write with bit 15 set, exercise the fields that must be ignored.

Random words then cover all mode values, channels and strobe timings, with the results checked against a model kept in the bench.

// File: rtl/dacfe_pkg.sv
`timescale 1ns/1ps
package dacfe_pkg;
    localparam int WORD_W  = 16;
    localparam int MAIN_W  = 10;
    localparam int SUB_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int BIAS_W  = 2;
    localparam logic [MAIN_W-1:0] MAIN_MID = 10'h200;
    localparam logic [SUB_W-1:0]  SUB_MID  = 8'h80;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_DRAIN = 2'd2
    } rx_state_t;
endpackage

// File: rtl/dacfe_serial_rx.sv
`timescale 1ns/1ps
module dacfe_serial_rx
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              fsync_n,
    input  logic              sdin,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [SYNC_STAGES-1:0] sclk_pipe, fs_pipe, sd_pipe;
    logic                   sclk_last;
    logic                   sclk_s, fs_s, sd_s;
    logic                   fall, accept, last_bit;
    logic [WORD_W-2:0]      shreg;
    logic [CNT_W-1:0]       cnt;
    rx_state_t              state, state_nxt;

    assign sclk_s   = sclk_pipe[SYNC_STAGES-1];
    assign fs_s     = fs_pipe[SYNC_STAGES-1];
    assign sd_s     = sd_pipe[SYNC_STAGES-1];
    assign fall     = sclk_last & ~sclk_s;
    assign accept   = fall & ~fs_s & (state != RX_DRAIN);
    assign last_bit = accept & (cnt == CNT_W'(WORD_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_pipe <= '0;
            fs_pipe   <= '1;
            sd_pipe   <= '0;
            sclk_last <= 1'b0;
        end else begin
            sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
            fs_pipe   <= {fs_pipe[SYNC_STAGES-2:0], fsync_n};
            sd_pipe   <= {sd_pipe[SYNC_STAGES-2:0], sdin};
            sclk_last <= sclk_s;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE:  if (!fs_s) state_nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (fs_s)          state_nxt = RX_IDLE;
                else if (last_bit) state_nxt = RX_DRAIN;
            end
            RX_DRAIN: if (fs_s) state_nxt = RX_IDLE;
            default:  state_nxt = RX_IDLE;
        endcase
    end

    // shift register and edge count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (fs_s) begin
            cnt <= '0;
        end else if (accept) begin
            shreg <= {shreg[WORD_W-3:0], sd_s};
            cnt   <= cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word       <= '0;
        end else begin
            word_valid <= last_bit;
            if (last_bit) word <= {shreg, sd_s};
        end
    end
endmodule

// File: rtl/dacfe_chan.sv
`timescale 1ns/1ps
module dacfe_chan
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    input  logic [MAIN_W-1:0] clr_main,
    input  logic              ldac_req,
    input  logic              wr_main,
    input  logic              wr_sub,
    input  logic [MAIN_W-1:0] wdata,
    output logic [MAIN_W-1:0] main_data,
    output logic [MAIN_W-1:0] main_dac,
    output logic [SUB_W-1:0]  sub_dac
);
    logic [SUB_W-1:0]  sub_data;
    logic [MAIN_W-1:0] main_nxt;
    logic [SUB_W-1:0]  sub_nxt;

    assign main_nxt = wr_main ? wdata : main_data;
    assign sub_nxt  = wr_sub  ? wdata[SUB_W-1:0] : sub_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_data <= MAIN_MID;
            main_dac  <= MAIN_MID;
            sub_data  <= SUB_MID;
            sub_dac   <= SUB_MID;
        end else if (clr_req) begin
            main_data <= clr_main;
            main_dac  <= clr_main;
            sub_data  <= SUB_MID;
            sub_dac   <= SUB_MID;
        end else begin
            main_data <= main_nxt;
            sub_data  <= sub_nxt;
            if (ldac_req) begin
                main_dac <= main_nxt;
                sub_dac  <= sub_nxt;
            end
        end
    end
endmodule

// File: rtl/dacfe_core.sv
`timescale 1ns/1ps
module dacfe_core
    import dacfe_pkg::*;
#(
    parameter int CHANNELS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       fsync_n,
    input  logic                       sdin,
    input  logic                       ldac_n,
    input  logic                       clr_n,
    output logic [CHANNELS*MAIN_W-1:0] main_code,
    output logic [CHANNELS*SUB_W-1:0]  sub_code,
    output logic                       coding_twos,
    output logic                       sys_standby,
    output logic                       sys_powerdown,
    output logic [CHANNELS-1:0]        ch_standby,
    output logic [CHANNELS*BIAS_W-1:0] ch_bias_sel
);
    logic                       word_valid;
    logic [WORD_W-1:0]          word;
    logic [CHANNELS*MAIN_W-1:0] main_data_flat;
    logic                       wr_sys, wr_ctl, wr_dat;
    logic [ADDR_W-1:0]          addr;
    logic [MAIN_W-1:0]          clr_main;

    dacfe_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n),
        .sdin(sdin), .word_valid(word_valid), .word(word)
    );

    assign wr_sys   = word_valid & (word[14:13] == 2'b00);
    assign wr_ctl   = word_valid & (word[14:13] == 2'b01);
    assign wr_dat   = word_valid & word[14];
    assign addr     = word[11:10];
    assign clr_main = coding_twos ? '0 : MAIN_MID;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coding_twos   <= 1'b0;
            sys_standby   <= 1'b0;
            sys_powerdown <= 1'b0;
        end else if (wr_sys) begin
            coding_twos   <= word[0];
            sys_standby   <= word[1];
            sys_powerdown <= word[2];
        end
    end

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        logic hit;
        assign hit = (addr == ADDR_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_standby[c]                 <= 1'b0;
                ch_bias_sel[c*BIAS_W +: BIAS_W] <= '0;
            end else if (wr_ctl && hit) begin
                ch_standby[c]                 <= word[0];
                ch_bias_sel[c*BIAS_W +: BIAS_W] <= word[2:1];
            end
        end

        dacfe_chan u_chan (
            .clk(clk), .rst_n(rst_n), .clr_req(~clr_n), .clr_main(clr_main),
            .ldac_req(~ldac_n),
            .wr_main(wr_dat & hit & ~word[12]),
            .wr_sub(wr_dat & hit & word[12]),
            .wdata(word[MAIN_W-1:0]),
            .main_data(main_data_flat[c*MAIN_W +: MAIN_W]),
            .main_dac(main_code[c*MAIN_W +: MAIN_W]),
            .sub_dac(sub_code[c*SUB_W +: SUB_W])
        );
    end
endmodule

// File: rtl/dacfe_core_chk.sv
`timescale 1ns/1ps
module dacfe_core_chk
    import dacfe_pkg::*;
#(
    parameter int CHANNELS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ldac_n,
    input logic                       clr_n,
    input logic                       coding_twos,
    input logic                       word_valid,
    input logic [CHANNELS*MAIN_W-1:0] main_code,
    input logic [CHANNELS*SUB_W-1:0]  sub_code,
    input logic [CHANNELS*MAIN_W-1:0] main_data
);
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_n && clr_n) |=> ($stable(main_code) && $stable(sub_code))); // R4

    AST_STROBE_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldac_n && clr_n) |=> (main_code == main_data)); // R5

    AST_CLEAR_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (sub_code == {CHANNELS{SUB_MID}})); // R7

    AST_CLEAR_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (main_code == ($past(coding_twos) ? {CHANNELS*MAIN_W{1'b0}}
                                                     : {CHANNELS{MAIN_MID}}))); // R7

    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R1
endmodule

bind dacfe_core dacfe_core_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n), .clr_n(clr_n),
    .coding_twos(coding_twos), .word_valid(word_valid),
    .main_code(main_code), .sub_code(sub_code), .main_data(main_data_flat)
);

// File: tb/dacfe_core_tb.sv
`timescale 1ns/1ps
module dacfe_core_tb;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, fsync_n = 1'b1, sdin = 1'b0;
    logic ldac_n = 1'b1, clr_n = 1'b1;
    logic [NCH*10-1:0] main_code;
    logic [NCH*8-1:0]  sub_code;
    logic coding_twos, sys_standby, sys_powerdown;
    logic [NCH-1:0]    ch_standby;
    logic [NCH*2-1:0]  ch_bias_sel;

    int total = 0;
    int bad   = 0;

    logic [9:0] m_dat [NCH];
    logic [9:0] m_dac [NCH];
    logic [7:0] s_dat [NCH];
    logic [7:0] s_dac [NCH];
    logic       e_twos, e_stby, e_pd;
    logic [NCH-1:0] e_cstby;
    logic [1:0] e_bias [NCH];

    always #2.5 clk = ~clk;

    dacfe_core #(.CHANNELS(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fsync_n(fsync_n), .sdin(sdin),
        .ldac_n(ldac_n), .clr_n(clr_n), .main_code(main_code), .sub_code(sub_code),
        .coding_twos(coding_twos), .sys_standby(sys_standby),
        .sys_powerdown(sys_powerdown), .ch_standby(ch_standby),
        .ch_bias_sel(ch_bias_sel)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_dat[c] = 10'h200; m_dac[c] = 10'h200;
            s_dat[c] = 8'h80;   s_dac[c] = 8'h80;
            e_bias[c] = 2'b00;
        end
        e_twos = 0; e_stby = 0; e_pd = 0; e_cstby = '0;
    endfunction

    function automatic void model_word(input logic [15:0] w);
        int ch;
        ch = int'(w[11:10]);
        case (w[14:13])
            2'b00: begin e_twos = w[0]; e_stby = w[1]; e_pd = w[2]; end
            2'b01: begin e_cstby[ch] = w[0]; e_bias[ch] = w[2:1]; end
            default: if (w[12]) s_dat[ch] = w[7:0]; else m_dat[ch] = w[9:0];
        endcase
    endfunction

    function automatic void model_ldac();
        for (int c = 0; c < NCH; c++) begin
            m_dac[c] = m_dat[c]; s_dac[c] = s_dat[c];
        end
    endfunction

    function automatic void model_clr();
        for (int c = 0; c < NCH; c++) begin
            m_dat[c] = e_twos ? 10'h000 : 10'h200; m_dac[c] = m_dat[c];
            s_dat[c] = 8'h80; s_dac[c] = 8'h80;
        end
    endfunction

    function automatic logic [NCH*10+NCH*8+NCH*3+2:0] expected();
        logic [NCH*10-1:0] em; logic [NCH*8-1:0] es; logic [NCH*2-1:0] eb;
        for (int c = 0; c < NCH; c++) begin
            em[c*10 +: 10] = m_dac[c]; es[c*8 +: 8] = s_dac[c]; eb[c*2 +: 2] = e_bias[c];
        end
        return {em, es, eb, e_cstby, e_twos, e_stby, e_pd};
    endfunction

    task automatic check(input string req);
        logic [NCH*10+NCH*8+NCH*3+2:0] act, exp_v;
        act   = {main_code, sub_code, ch_bias_sel, ch_standby,
                 coding_twos, sys_standby, sys_powerdown};
        exp_v = expected();
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int nbits, input bit hold_ldac);
        if (hold_ldac) ldac_n = 1'b0;
        fsync_n = 1'b0;
        wait_clks(3);
        for (int i = 0; i < nbits; i++) begin
            sdin = bits[nbits-1-i];
            sclk = 1'b1; wait_clks(4);
            sclk = 1'b0; wait_clks(4);
        end
        wait_clks(3);
        fsync_n = 1'b1;
        wait_clks(8);
        ldac_n = 1'b1;
        wait_clks(2);
    endtask

    task automatic send_word(input logic [15:0] w, input bit hold_ldac);
        send_bits({16'h0, w}, 16, hold_ldac);
        model_word(w);
        if (hold_ldac) model_ldac();
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0; wait_clks(2); ldac_n = 1'b1; wait_clks(2);
        model_ldac();
    endtask

    task automatic pulse_clr();
        clr_n = 1'b0; wait_clks(2); clr_n = 1'b1; wait_clks(2);
        model_clr();
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4711));
        model_reset();
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(2);
        check("R9 reset state");

        // main write ch1, no strobe: outputs must hold
        send_word(16'h4000 | (16'd1 << 10) | 16'h155, 1'b0);
        check("R4 write without strobe");
        pulse_ldac();
        check("R5/R1 strobe after MSB-first main write");

        // sub write ch2 with junk in bits 9:8
        send_word(16'h5000 | (16'd2 << 10) | 16'h33C, 1'b0);
        pulse_ldac();
        check("R2 sub write ignores upper bits");

        // automatic update with strobe held low
        send_word(16'h4000 | (16'd3 << 10) | 16'h2AB, 1'b1);
        check("R6 automatic update");

        // short frame discarded
        send_bits({22'h0, 10'h3FF}, 10, 1'b0);
        pulse_ldac();
        check("R3 short frame discarded");
        send_word(16'h4000 | 16'h0FA, 1'b0);
        pulse_ldac();
        check("R3 full frame after short one");

        // long frame: only first 16 edges count
        w = 16'h5000 | (16'd0 << 10) | 16'h0A5;
        send_bits({12'h0, w, 4'hF}, 20, 1'b0);
        model_word(w);
        pulse_ldac();
        check("R3 extra edges ignored");

        // reserved bit 15 set
        send_word(16'hC000 | (16'd2 << 10) | 16'h1E1, 1'b1);
        check("R10 reserved bit ignored");

        // control writes
        send_word(16'h0007, 1'b0);
        check("R8 system control");
        send_word(16'h2000 | (16'd1 << 10) | 16'h0005, 1'b0);
        send_word(16'h2000 | (16'd3 << 10) | 16'h0002, 1'b0);
        check("R8 channel control");

        // clear under both codings
        send_word(16'h4000 | (16'd0 << 10) | 16'h111, 1'b0);
        pulse_clr();
        check("R7 clear twos complement");
        send_word(16'h0000, 1'b0);
        send_word(16'h5000 | (16'd1 << 10) | 16'h011, 1'b1);
        pulse_clr();
        check("R7 clear offset binary");

        for (int it = 0; it < 80; it++) begin
            w = 16'($urandom);
            send_word(w, ($urandom % 4) == 0);
            if (it % 5 == 4) pulse_ldac();
            if (it % 13 == 12) pulse_clr();
            check("R2 random word");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule